// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

The router gathers the interrupt lines that belong to a four-core cluster and turns them into one IRQ and one FIQ line per core. Each core owns four timer lines, four mailbox request lines, a performance-monitor line, an AXI error line and a local-timer line. A single GPU line is shared by the whole cluster. Mailbox logic and timers sit outside the block and arrive here as plain levels.

Software sets the routing through a small register window. Timers and mailboxes are enabled per core through a configuration register that has an IRQ half and an FIQ half. The GPU line is steered to one IRQ target core and one FIQ target core by two encoded fields. The performance-monitor enables are changed through separate set and clear addresses, so each core can update its own bits without a read-modify-write. Every core also has a read-only pending word with a fixed bit layout that shows the live source levels.

Top module: `core_irq_router`

## Requirements
- R1: After reset all configuration registers read 0. With the GPU line low, no IRQ or FIQ output is asserted whatever the other source levels are. A raised GPU line reaches only core 0, and only on FIQ, because both GPU target fields reset to core 0 (see R6).
- R2: The pending word of core n reads at 0x60+4n. Bits 3:0 are timers 0..3, bits 7:4 are mailboxes 0..3, bit 8 is GPU, bit 9 is the performance monitor, bit 10 is AXI error and bit 11 is the local timer. The word follows the input levels in the same cycle.
- R3: The timer config of core n is at 0x40+4n. Bit t (t=0..3) enables timer t onto IRQ and bit 4+t enables it onto FIQ. A timer that is FIQ-enabled never drives IRQ.
- R4: The mailbox config of core n is at 0x50+4n and uses the same layout and FIQ precedence as R3 for mailboxes 0..3.
- R5: The GPU routing register is at 0x0C. Bits [1:0] name the IRQ target core and bits [3:2] name the FIQ target core. GPU pending bit 8 shows only in the pending words of those target cores.
- R6: When one core is both the GPU IRQ target and the GPU FIQ target, the GPU line drives only that core's FIQ.
- R7: Writing ones at 0x10 sets performance-monitor enable bits and writing ones at 0x14 clears them. Zero bits leave the enable unchanged. Bit n is the IRQ enable and bit 4+n is the FIQ enable for core n, with FIQ taking precedence. Reads at either address return the current enable byte.
- R8: The control register at 0x00 and the prescaler at 0x08 are 32-bit read/write storage (for example 0x80000000 reads back unchanged) and have no effect on any output.
- R9: The AXI error and local-timer bits show in the pending word but never drive IRQ or FIQ.
- R10: Writes to the pending words or to unmapped addresses change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_lvl | input | 16 | Timer levels, core n at [4n+3:4n] |
| mbx_lvl | input | 16 | Mailbox request levels, core n at [4n+3:4n] |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 4 | Performance-monitor level per core |
| axi_lvl | input | 4 | AXI error level per core |
| ltm_lvl | input | 4 | Local timer level per core |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
The bench aims at the FIQ-over-IRQ precedence for every source class. A design that leaked a FIQ-enabled source onto IRQ would assert both lines of a core. The GPU cases cover IRQ and FIQ targets on different cores and on the same core. A wrong field decode would move the pending bit or the outputs to the wrong core, and missing precedence would raise IRQ as well. Set and clear writes with sparse masks catch a clear address that overwrites the enables instead of removing only the bits written. Writes to pending words and unmapped addresses, together with high AXI and local-timer levels, catch decoders that alias registers or let those two bits reach an output.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NCORES = 4;
  localparam int NSRC   = 4;
  localparam int AW     = 8;
  localparam int DW     = 32;

  localparam int A_CTRL  = 'h00;
  localparam int A_PRESC = 'h08;
  localparam int A_GPU   = 'h0C;
  localparam int A_PSET  = 'h10;
  localparam int A_PCLR  = 'h14;
  localparam int A_TCFG  = 'h40;
  localparam int A_MCFG  = 'h50;
  localparam int A_PEND  = 'h60;

  localparam int B_TMR  = 0;
  localparam int B_MBX  = 4;
  localparam int B_GPU  = 8;
  localparam int B_PMU  = 9;
  localparam int B_AXI  = 10;
  localparam int B_LTM  = 11;
  localparam int PEND_W = 12;

  typedef struct packed {
    logic [NSRC-1:0] fiq;
    logic [NSRC-1:0] irq;
  } en_pair_t;
endpackage

// File: rtl/rtr_regs.sv
module rtr_regs
  import rtr_pkg::*;
#(
  parameter int NC = NCORES,
  localparam int CW = $clog2(NC),
  localparam int GW = 2 * CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        ctrl_q,
  output logic [DW-1:0]        presc_q,
  output logic [GW-1:0]        gpu_q,
  output en_pair_t             pmu_q,
  output en_pair_t [NC-1:0]    tcfg_q,
  output en_pair_t [NC-1:0]    mcfg_q
);
  localparam int EW = $bits(en_pair_t);

  logic [DW-1:0]     ctrl_d, presc_d;
  logic [GW-1:0]     gpu_d;
  en_pair_t          pmu_d;
  en_pair_t [NC-1:0] tcfg_d, mcfg_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    gpu_d   = gpu_q;
    pmu_d   = pmu_q;
    tcfg_d  = tcfg_q;
    mcfg_d  = mcfg_q;
    if (addr == AW'(A_CTRL))  ctrl_d  = wdata;
    if (addr == AW'(A_PRESC)) presc_d = wdata;
    if (addr == AW'(A_GPU))   gpu_d   = wdata[GW-1:0];
    if (addr == AW'(A_PSET))  pmu_d   = pmu_q | wdata[EW-1:0];
    if (addr == AW'(A_PCLR))  pmu_d   = pmu_q & ~wdata[EW-1:0];
    for (int n = 0; n < NC; n++) begin
      if (addr == AW'(A_TCFG + 4 * n)) tcfg_d[n] = wdata[EW-1:0];
      if (addr == AW'(A_MCFG + 4 * n)) mcfg_d[n] = wdata[EW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      gpu_q   <= '0;
      pmu_q   <= '0;
      tcfg_q  <= '0;
      mcfg_q  <= '0;
    end else if (we) begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      gpu_q   <= gpu_d;
      pmu_q   <= pmu_d;
      tcfg_q  <= tcfg_d;
      mcfg_q  <= mcfg_d;
    end
  end

  // R7: bits written at the set address are all present afterwards
  a_r7_pmu_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(A_PSET)) |=> ((pmu_q & $past(wdata[EW-1:0])) == $past(wdata[EW-1:0])));
  // R7: bits written at the clear address are all gone afterwards
  a_r7_pmu_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(A_PCLR)) |=> ((pmu_q & $past(wdata[EW-1:0])) == '0));
  // R10: no write strobe, no configuration change
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(tcfg_q) && $stable(mcfg_q) && $stable(pmu_q) && $stable(gpu_q)));
endmodule

// File: rtl/rtr_lane.sv
module rtr_lane
  import rtr_pkg::*;
#(
  parameter int NC = NCORES,
  parameter int CORE_ID = 0,
  localparam int CW = $clog2(NC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   tmr,
  input  logic [NSRC-1:0]   mbx,
  input  logic              gpu,
  input  logic              pmu,
  input  logic              axi,
  input  logic              ltm,
  input  en_pair_t          tcfg,
  input  en_pair_t          mcfg,
  input  logic [CW-1:0]     gpu_irq_core,
  input  logic [CW-1:0]     gpu_fiq_core,
  input  logic              pmu_irq_en,
  input  logic              pmu_fiq_en,
  output logic [PEND_W-1:0] pend,
  output logic              irq,
  output logic              fiq
);
  logic              gpu_to_irq, gpu_to_fiq;
  logic [PEND_W-1:0] fiq_mask, irq_mask;

  always_comb begin
    gpu_to_irq = (gpu_irq_core == CW'(CORE_ID));
    gpu_to_fiq = (gpu_fiq_core == CW'(CORE_ID));
    pend = '0;
    pend[B_TMR +: NSRC] = tmr;
    pend[B_MBX +: NSRC] = mbx;
    pend[B_GPU] = gpu & (gpu_to_irq | gpu_to_fiq);
    pend[B_PMU] = pmu;
    pend[B_AXI] = axi;
    pend[B_LTM] = ltm;

    fiq_mask = '0;
    fiq_mask[B_TMR +: NSRC] = tcfg.fiq;
    fiq_mask[B_MBX +: NSRC] = mcfg.fiq;
    fiq_mask[B_GPU] = gpu_to_fiq;
    fiq_mask[B_PMU] = pmu_fiq_en;

    irq_mask = '0;
    irq_mask[B_TMR +: NSRC] = tcfg.irq;
    irq_mask[B_MBX +: NSRC] = mcfg.irq;
    irq_mask[B_GPU] = gpu_to_irq;
    irq_mask[B_PMU] = pmu_irq_en;
    irq_mask = irq_mask & ~fiq_mask;

    irq = |(pend & irq_mask);
    fiq = |(pend & fiq_mask);
  end

  // R9: with only AXI / local-timer bits pending, the core stays quiet
  a_r9_side_bits_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[B_AXI-1:0] == '0) |-> (!irq && !fiq));
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import rtr_pkg::*;
#(
  parameter int NC = NCORES,
  localparam int CW = $clog2(NC),
  localparam int GW = 2 * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NC*NSRC-1:0] tmr_lvl,
  input  logic [NC*NSRC-1:0] mbx_lvl,
  input  logic               gpu_lvl,
  input  logic [NC-1:0]      pmu_lvl,
  input  logic [NC-1:0]      axi_lvl,
  input  logic [NC-1:0]      ltm_lvl,
  output logic [NC-1:0]      core_irq,
  output logic [NC-1:0]      core_fiq
);
  logic [DW-1:0]     ctrl_q, presc_q;
  logic [GW-1:0]     gpu_q;
  en_pair_t          pmu_q;
  en_pair_t [NC-1:0] tcfg_q, mcfg_q;
  logic [PEND_W-1:0] pend [NC];
  logic [NC-1:0]     gpu_pend_vec;

  rtr_regs #(.NC(NC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .presc_q(presc_q), .gpu_q(gpu_q), .pmu_q(pmu_q),
    .tcfg_q(tcfg_q), .mcfg_q(mcfg_q)
  );

  for (genvar c = 0; c < NC; c++) begin : g_lane
    rtr_lane #(.NC(NC), .CORE_ID(c)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .tmr(tmr_lvl[c*NSRC +: NSRC]), .mbx(mbx_lvl[c*NSRC +: NSRC]),
      .gpu(gpu_lvl), .pmu(pmu_lvl[c]), .axi(axi_lvl[c]), .ltm(ltm_lvl[c]),
      .tcfg(tcfg_q[c]), .mcfg(mcfg_q[c]),
      .gpu_irq_core(gpu_q[CW-1:0]), .gpu_fiq_core(gpu_q[GW-1:CW]),
      .pmu_irq_en(pmu_q.irq[c]), .pmu_fiq_en(pmu_q.fiq[c]),
      .pend(pend[c]), .irq(core_irq[c]), .fiq(core_fiq[c])
    );
    assign gpu_pend_vec[c] = pend[c][B_GPU];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CTRL))  bus_rdata = ctrl_q;
    if (bus_addr == AW'(A_PRESC)) bus_rdata = presc_q;
    if (bus_addr == AW'(A_GPU))   bus_rdata = DW'(gpu_q);
    if (bus_addr == AW'(A_PSET) || bus_addr == AW'(A_PCLR)) bus_rdata = DW'(pmu_q);
    for (int n = 0; n < NC; n++) begin
      if (bus_addr == AW'(A_TCFG + 4 * n)) bus_rdata = DW'(tcfg_q[n]);
      if (bus_addr == AW'(A_MCFG + 4 * n)) bus_rdata = DW'(mcfg_q[n]);
      if (bus_addr == AW'(A_PEND + 4 * n)) bus_rdata = DW'(pend[n]);
    end
  end

  // R5: the shared GPU line shows in at most two pending words
  a_r5_gpu_two_targets: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gpu_pend_vec) <= 2);
  // R5: a low GPU line shows nowhere
  a_r5_gpu_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !gpu_lvl |-> (gpu_pend_vec == '0));
  // R3/R6: FIQ precedence leaves at least one line low for a core with only GPU pending to it
  a_r6_gpu_fiq_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gpu_q[CW-1:0] == gpu_q[GW-1:CW] && gpu_lvl && tmr_lvl == '0 && mbx_lvl == '0 && pmu_lvl == '0)
      |-> (core_irq == '0));
endmodule

// File: tb/sim_core_irq_router.sv
module sim_core_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_lvl = '0, mbx_lvl = '0;
  logic        gpu_lvl = 1'b0;
  logic [3:0]  pmu_lvl = '0, axi_lvl = '0, ltm_lvl = '0;
  logic [3:0]  core_irq, core_fiq;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  int m_ctrl, m_presc, m_gpu, m_pmu;
  int m_t[4], m_m[4];

  always #2.5 clk = ~clk;

  core_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lvl(tmr_lvl),
    .mbx_lvl(mbx_lvl), .gpu_lvl(gpu_lvl), .pmu_lvl(pmu_lvl), .axi_lvl(axi_lvl),
    .ltm_lvl(ltm_lvl), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_presc = 0; m_gpu = 0; m_pmu = 0;
      for (int i = 0; i < 4; i++) begin m_t[i] = 0; m_m[i] = 0; end
    end else if (bus_we) begin
      case (int'(bus_addr))
        'h00: m_ctrl = bus_wdata;
        'h08: m_presc = bus_wdata;
        'h0C: m_gpu = bus_wdata & 'hF;
        'h10: m_pmu = m_pmu | (bus_wdata & 'hFF);
        'h14: m_pmu = m_pmu & ~(bus_wdata & 'hFF);
        default: begin
          for (int i = 0; i < 4; i++) begin
            if (int'(bus_addr) == 'h40 + 4*i) m_t[i] = bus_wdata & 'hFF;
            if (int'(bus_addr) == 'h50 + 4*i) m_m[i] = bus_wdata & 'hFF;
          end
        end
      endcase
    end
  end

  function automatic int gpu_targets(int c);
    return gpu_lvl && (((m_gpu & 3) == c) || (((m_gpu >> 2) & 3) == c));
  endfunction

  function automatic int exp_pend(int c);
    int v;
    v = (tmr_lvl >> (4*c)) & 'hF;
    v |= ((mbx_lvl >> (4*c)) & 'hF) << 4;
    if (gpu_targets(c) != 0) v |= 1 << 8;
    if (pmu_lvl[c]) v |= 1 << 9;
    if (axi_lvl[c]) v |= 1 << 10;
    if (ltm_lvl[c]) v |= 1 << 11;
    return v;
  endfunction

  // returns {fiq, irq}
  function automatic int exp_lines(int c);
    int irq, fiq;
    irq = 0; fiq = 0;
    for (int s = 0; s < 4; s++) begin
      if (tmr_lvl[4*c+s]) begin
        if ((m_t[c] >> (4+s)) & 1) fiq = 1; else if ((m_t[c] >> s) & 1) irq = 1;
      end
      if (mbx_lvl[4*c+s]) begin
        if ((m_m[c] >> (4+s)) & 1) fiq = 1; else if ((m_m[c] >> s) & 1) irq = 1;
      end
    end
    if (gpu_lvl) begin
      if (((m_gpu >> 2) & 3) == c) fiq = 1; else if ((m_gpu & 3) == c) irq = 1;
    end
    if (pmu_lvl[c]) begin
      if ((m_pmu >> (4+c)) & 1) fiq = 1; else if ((m_pmu >> c) & 1) irq = 1;
    end
    return (fiq << 1) | irq;
  endfunction

  function automatic int exp_read(int a);
    case (a)
      'h00: return m_ctrl;
      'h08: return m_presc;
      'h0C: return m_gpu;
      'h10, 'h14: return m_pmu;
      default: begin
        for (int i = 0; i < 4; i++) begin
          if (a == 'h40 + 4*i) return m_t[i];
          if (a == 'h50 + 4*i) return m_m[i];
          if (a == 'h60 + 4*i) return exp_pend(i);
        end
        return 0;
      end
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("rdata", int'(bus_rdata), exp_read(int'(bus_addr)));
      for (int c = 0; c < 4; c++) begin
        chk($sformatf("irq%0d", c), int'(core_irq[c]), exp_lines(c) & 1);
        chk($sformatf("fiq%0d", c), int'(core_fiq[c]), (exp_lines(c) >> 1) & 1);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(int a);
    bus_addr = 8'(a);
    step();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset readback, levels high but nothing routed
    tag = "R1";
    foreach (m_t[i]) rd('h40 + 4*i);
    rd('h00); rd('h08); rd('h0C); rd('h10);
    tmr_lvl = '1; mbx_lvl = '1; pmu_lvl = '1; step(); step();
    gpu_lvl = 1'b1; step(); step();
    tmr_lvl = '0; mbx_lvl = '0; pmu_lvl = '0; gpu_lvl = 1'b0;
    // R2: pending layout
    tag = "R2";
    tmr_lvl = 16'h8421; mbx_lvl = 16'h1248; pmu_lvl = 4'b0101;
    for (int c = 0; c < 4; c++) rd('h60 + 4*c);
    tmr_lvl = 16'h5A3C; mbx_lvl = 16'hC3A5; pmu_lvl = 4'b1010;
    for (int c = 0; c < 4; c++) rd('h60 + 4*c);
    // R3: timer routing with FIQ precedence
    tag = "R3";
    wr('h40, 'h21); wr('h44, 'h3C); wr('h48, 'hF0); wr('h4C, 'h0F);
    tmr_lvl = 16'hFFFF; mbx_lvl = '0; pmu_lvl = '0; step();
    tmr_lvl = 16'h1248; step(); tmr_lvl = 16'h8421; step();
    rd('h44);
    // R4: mailbox routing
    tag = "R4";
    tmr_lvl = '0;
    wr('h50, 'h12); wr('h54, 'h84); wr('h58, 'h0F); wr('h5C, 'hFF);
    mbx_lvl = 16'hFFFF; step(); mbx_lvl = 16'h2222; step(); rd('h5C);
    mbx_lvl = '0;
    // R5: GPU split between two cores
    tag = "R5";
    wr('h0C, 2 | (1 << 2)); gpu_lvl = 1'b1;
    for (int c = 0; c < 4; c++) rd('h60 + 4*c);
    wr('h0C, 3); rd('h0C);
    // R6: GPU to one core on both fields
    tag = "R6";
    wr('h0C, 'hF); rd('h6C); rd('h64);
    gpu_lvl = 1'b0;
    // R7: performance-monitor set / clear
    tag = "R7";
    pmu_lvl = '1;
    wr('h10, 'h0F); rd('h10);
    wr('h10, 'h30); rd('h14);
    wr('h14, 'h05); rd('h10);
    wr('h14, 'h00); rd('h14);
    wr('h14, 'hFF); rd('h10);
    pmu_lvl = '0;
    // R8: control and prescaler storage
    tag = "R8";
    wr('h08, 32'h80000000); rd('h08);
    wr('h00, 32'hFFFFFFFF); tmr_lvl = 16'h000F; rd('h00);
    // R9: AXI and local timer never route
    tag = "R9";
    tmr_lvl = '0; axi_lvl = '1; ltm_lvl = 4'b0110;
    for (int c = 0; c < 4; c++) rd('h60 + 4*c);
    axi_lvl = '0; ltm_lvl = '0;
    // R10: pending and unmapped addresses are not writable
    tag = "R10";
    wr('h60, 'hFFF); rd('h60);
    wr('h20, 'hFF); rd('h20);
    wr('hFC, 'h12345678); rd('hFC); rd('h40);
    // mixed traffic
    tag = "R3";
    lfsr = 'h1ACE;
    for (int k = 0; k < 400; k++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      tmr_lvl = 16'(lfsr); mbx_lvl = 16'(lfsr * 7); gpu_lvl = lfsr[3];
      pmu_lvl = 4'(lfsr >> 5); axi_lvl = 4'(lfsr >> 9); ltm_lvl = 4'(lfsr >> 2);
      case (k % 5)
        0: wr('h40 + 4*(lfsr & 3), lfsr >> 4);
        1: wr('h50 + 4*((lfsr >> 2) & 3), lfsr >> 6);
        2: wr('h0C, lfsr >> 3);
        3: wr((lfsr & 1) ? 'h10 : 'h14, lfsr >> 8);
        default: rd('h60 + 4*(lfsr & 3));
      endcase
    end
    step();
    finish_run();
  end
endmodule